// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase outputs of an incremental rotary or linear encoder into a position count. Each phase input first passes through its own synchronizer chain. A step decoder then compares each synchronized level with its value one cycle earlier to find edges. It keeps the edges of the channels selected by the mode input, drops any cycle in which both channels change, and takes the direction of each step from the level of the other channel. The counter applies each accepted step and runs around the range 0 to `preset` in either direction, so its value holds the shaft angle as a fraction of one revolution.

There are three counting resolutions. One counts only phase-B edges, one counts only phase-A edges, and one counts the edges of both phases, which gives four counts per quadrature cycle. A fourth mode value freezes the count. The direction flag shows the sense of the last step that was counted.

Top module: `qenc_counter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release with both phases held low, `count` is 0 and `dir_down` is 0.
- R2: With `mode_sel` = 2'b01, only phase-B edges are counted and phase-A edges leave the count unchanged. A B edge counts up when the new B level equals the A level, and counts down otherwise.
- R3: With `mode_sel` = 2'b10, only phase-A edges are counted and phase-B edges leave the count unchanged. An A edge counts up when the new A level differs from the B level, and counts down otherwise.
- R4: With `mode_sel` = 2'b11, edges of both phases are counted by the rules of R2 and R3. A full forward quadrature cycle (AB = 00, 10, 11, 01, 00) therefore adds four.
- R5: With `mode_sel` = 2'b00, no edge changes `count` or `dir_down`.
- R6: A step up taken while `count` is greater than or equal to `preset` loads 0. Any other step up adds one.
- R7: A step down taken while `count` is 0 loads `preset`. Any other step down subtracts one.
- R8: `dir_down` becomes 1 after a counted down step and 0 after a counted up step. It holds its value in cycles without a counted step.
- R9: A cycle in which both synchronized phases change at once is an invalid transition. It changes neither `count` nor `dir_down`, in any mode.
- R10: With two synchronizer stages, a phase change driven before clock edge k shows on `count` after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| mode_sel | input | 2 | 00 hold, 01 B edges, 10 A edges, 11 both |
| preset | input | CNT_W | Top of the counting range |
| count | output | CNT_W | Position count |
| dir_down | output | 1 | 1 when the last counted step was down |

## Verification
The bench builds the counter with CNT_W = 8 and the default two synchronizer stages, and drives `preset` at 5. With the range this short, a few quadrature steps reach both wrap points, once going forward and once going backward. The vector walk passes through all four modes and through simultaneous phase changes. A directed test counts the cycles of the two-stage latency. Another lowers `preset` below the current count and checks that the next up step still wraps to 0.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   typedef enum logic [1:0] {
      QM_HOLD    = 2'b00,
      QM_EDGE_B  = 2'b01,
      QM_EDGE_A  = 2'b10,
      QM_EDGE_AB = 2'b11
   } qmode_t;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int STAGES = 2,
   parameter int LANES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] d_async,
   output logic [LANES-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qenc_sync: STAGES must be at least 2");
      end
   endgenerate

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d_async[ln]};
      end
      assign q_sync[ln] = chain[STAGES-1];
   end
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
   import qenc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   a_lvl,
   input  logic   b_lvl,
   input  qmode_t mode,
   output logic   step_en,
   output logic   step_dn
);
   logic a_q, b_q;
   logic a_edge, b_edge;
   logic use_a, use_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         a_q <= a_lvl;
         b_q <= b_lvl;
      end
   end

   assign a_edge = a_lvl ^ a_q;
   assign b_edge = b_lvl ^ b_q;

   always_comb begin
      use_a = 1'b0;
      use_b = 1'b0;
      unique case (mode)
         QM_EDGE_B:  use_b = 1'b1;
         QM_EDGE_A:  use_a = 1'b1;
         QM_EDGE_AB: begin use_a = 1'b1; use_b = 1'b1; end
         default:    ;
      endcase
   end

   always_comb begin
      step_en = 1'b0;
      step_dn = 1'b0;
      if (a_edge && b_edge) begin
         step_en = 1'b0;
      end else if (a_edge && use_a) begin
         step_en = 1'b1;
         step_dn = (a_lvl == b_lvl);
      end else if (b_edge && use_b) begin
         step_en = 1'b1;
         step_dn = (b_lvl != a_lvl);
      end
   end

   // R9: a double transition never produces a step
   assert_no_double_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_lvl != a_q && b_lvl != b_q) |-> !step_en);

   // R5: hold mode never produces a step
   assert_hold_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == QM_HOLD) |-> !step_en);

   // R2: in B-only mode a step needs a B transition
   assert_b_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == QM_EDGE_B && step_en) |-> (b_lvl != b_q));

   // R3: in A-only mode a step needs an A transition
   assert_a_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == QM_EDGE_A && step_en) |-> (a_lvl != a_q));
endmodule

// File: rtl/qenc_wrap_counter.sv
module qenc_wrap_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_en,
   input  logic         step_dn,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         dir_down
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] nxt;

   always_comb begin
      nxt = count;
      if (step_en) begin
         if (step_dn) nxt = (count == '0) ? limit : count - ONE;
         else         nxt = (count >= limit) ? '0 : count + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         dir_down <= 1'b0;
      end else begin
         count <= nxt;
         if (step_en) dir_down <= step_dn;
      end
   end

   // R6: an up step at or above the limit lands on zero
   assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_dn && count >= limit) |=> (count == '0));

   // R7: a down step from zero lands on the limit
   assert_wrap_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_dn && count == '0) |=> (count == $past(limit)));

   // R8: the flag follows the sense of each counted step
   assert_dir_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> (dir_down == $past(step_dn)));

   // R8: no step, no change
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> ($stable(count) && $stable(dir_down)));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
   import qenc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             phase_a_i,
   input  logic             phase_b_i,
   input  logic [1:0]       mode_sel,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] count,
   output logic             dir_down
);
   localparam int LANES = 2;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("qenc_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [LANES-1:0] lvl;
   logic             step_en, step_dn;

   qenc_sync #(.STAGES(SYNC_STAGES), .LANES(LANES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({phase_b_i, phase_a_i}),
      .q_sync  (lvl)
   );

   qenc_step_decode u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_lvl   (lvl[0]),
      .b_lvl   (lvl[1]),
      .mode    (qmode_t'(mode_sel)),
      .step_en (step_en),
      .step_dn (step_dn)
   );

   qenc_wrap_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .step_dn  (step_dn),
      .limit    (preset),
      .count    (count),
      .dir_down (dir_down)
   );

   // R1: state just after reset release is zero
   assert_reset_state_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (count == '0 && dir_down == 1'b0));
endmodule

// File: tb/sim_qenc_counter.sv
module sim_qenc_counter;
   localparam int W = 8;
   localparam int NV = 22;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pa = 1'b0, pb = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic [W-1:0] preset = 8'd5;
   logic [W-1:0] count;
   logic         dir_down;
   int           n_chk = 0, n_bad = 0;
   bit           done = 1'b0;

   always #5 clk = ~clk;

   qenc_counter #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .phase_a_i(pa), .phase_b_i(pb),
      .mode_sel(mode), .preset(preset), .count(count), .dir_down(dir_down)
   );

   // {mode[1:0], A, B, expected count[7:0], expected dir}
   localparam logic [12:0] VECS [NV] = '{
      {2'd3, 1'b1, 1'b0, 8'd1, 1'b0},  // R4 up
      {2'd3, 1'b1, 1'b1, 8'd2, 1'b0},  // R4
      {2'd3, 1'b0, 1'b1, 8'd3, 1'b0},  // R4
      {2'd3, 1'b0, 1'b0, 8'd4, 1'b0},  // R4 four per cycle
      {2'd3, 1'b1, 1'b0, 8'd5, 1'b0},
      {2'd3, 1'b1, 1'b1, 8'd0, 1'b0},  // R6 wrap up
      {2'd3, 1'b1, 1'b0, 8'd5, 1'b1},  // R7 wrap down
      {2'd3, 1'b0, 1'b0, 8'd4, 1'b1},
      {2'd3, 1'b0, 1'b1, 8'd3, 1'b1},
      {2'd1, 1'b1, 1'b1, 8'd3, 1'b1},  // R2 A edge ignored
      {2'd1, 1'b1, 1'b0, 8'd2, 1'b1},  // R2 down
      {2'd1, 1'b1, 1'b1, 8'd3, 1'b0},  // R2 up
      {2'd2, 1'b1, 1'b0, 8'd3, 1'b0},  // R3 B edge ignored
      {2'd2, 1'b0, 1'b0, 8'd2, 1'b1},  // R3 down
      {2'd2, 1'b1, 1'b0, 8'd3, 1'b0},  // R3 up
      {2'd2, 1'b1, 1'b1, 8'd3, 1'b0},  // R3 B edge ignored
      {2'd2, 1'b0, 1'b1, 8'd4, 1'b0},  // R3 up
      {2'd0, 1'b1, 1'b1, 8'd4, 1'b0},  // R5
      {2'd0, 1'b0, 1'b1, 8'd4, 1'b0},  // R5
      {2'd3, 1'b1, 1'b0, 8'd4, 1'b0},  // R9 both change
      {2'd3, 1'b0, 1'b1, 8'd4, 1'b0},  // R9 both change
      {2'd3, 1'b1, 1'b1, 8'd3, 1'b1}   // R4 A rise, equal -> down
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 count in reset", int'(count), 0);
      check("R1 dir in reset", int'(dir_down), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 count after release", int'(count), 0);

      for (int i = 0; i < NV; i++) begin
         mode = VECS[i][12:11];
         pa   = VECS[i][10];
         pb   = VECS[i][9];
         repeat (4) @(negedge clk);
         check($sformatf("R2-table vec %0d count", i), int'(count), int'(VECS[i][8:1]));
         check($sformatf("R8 vec %0d dir", i), int'(dir_down), int'(VECS[i][0]));
      end

      // R10: state AB=11, count 3; B falls -> down step, visible after 3 edges
      mode = 2'd3;
      pb = 1'b0;
      repeat (2) @(negedge clk);
      check("R10 not yet updated", int'(count), 3);
      @(negedge clk);
      check("R10 updated on third edge", int'(count), 2);
      check("R8 dir after down", int'(dir_down), 1);

      // R6: preset lowered below count; up step still wraps to zero
      preset = 8'd1;
      pb = 1'b1;
      repeat (4) @(negedge clk);
      check("R6 wrap with count above preset", int'(count), 0);
      check("R8 dir after up", int'(dir_down), 0);

      // R7: down step from zero loads the new preset
      pb = 1'b0;
      repeat (4) @(negedge clk);
      check("R7 wrap down to preset", int'(count), 1);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule